// File: doc/BRIEF.md
# Virtual address segment decoder

This block sits between a processor's address generation and its translation buffer. Each request carries a 32-bit virtual address, the current privilege level and the error-level status flag. The block sorts the address into one of five fixed regions by its top bits. For regions that bypass translation it computes the physical address itself. For translated regions it issues a lookup on a TLB port and forwards the answer. When the current privilege level may not touch a region, it returns a bad-address fault.

A build-time option replaces the region decoder with a fixed offset map for cores that have no translation buffer. In that variant every request completes locally and always matches.

Results leave through a registered port. It carries a valid pulse, a result code in the same 3-bit encoding the TLB uses, the physical address and read and write permission bits. Only one translated request may be in flight. The block lowers its ready output until the TLB answers.

Top module: `vaddr_seg_decode`

## Requirements
- R1: A virtual address below 0x8000_0000 with the error-level flag clear is sent to the TLB (tlb_req_valid high in the accepting cycle, tlb_vaddr equal to the request address) in every privilege level. With the flag set, it completes directly with physical address equal to the virtual address, code 3'b000, read and write both 1.
- R2: In kernel level (code 2'b00), an address in 0x8000_0000..0x9FFF_FFFF completes directly. The physical address is the address minus 0x8000_0000, with code 3'b000, read and write both 1.
- R3: In kernel level, an address in 0xA000_0000..0xBFFF_FFFF completes directly. The physical address is the address minus 0xA000_0000, with code 3'b000, read and write both 1.
- R4: Addresses in 0xC000_0000..0xDFFF_FFFF go to the TLB in kernel or supervisor level (2'b01), whatever the error-level flag. In user level they fault.
- R5: Addresses in 0xE000_0000..0xFFFF_FFFF go to the TLB in kernel level only. In supervisor and user level they fault.
- R6: A fault returns code 3'b111 with physical address 0 and read and write both 0. This covers the two direct regions outside kernel level. Level 2'b10 is user, and 2'b11 is treated as user.
- R7: A request completed without the TLB shows its result on the outputs one cycle after acceptance. out_valid is high for exactly that one cycle.
- R8: For a TLB lookup, the outputs carry tlb_rsp_code, tlb_rsp_pa, tlb_rsp_rd and tlb_rsp_wr unchanged, one cycle after tlb_rsp_valid. The TLB may answer in the request cycle or later. From the cycle after a lookup is issued until the answer cycle, req_ready is low and requests offered are not taken.
- R9: With FIXED_MAP=1, three mappings apply. An address below 0x8000_0000 maps to address + 0x4000_0000, or to itself when the error-level flag is set. An address in 0x8000_0000..0xBFFF_FFFF keeps its low 29 bits. Higher addresses map to themselves. Every request completes with code 3'b000 and read and write both 1, no TLB lookup is issued and privilege level is ignored.
- R10: During and just after reset, out_valid and tlb_req_valid are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_priv | input | 2 | Privilege level: 00 kernel, 01 supervisor, 10/11 user |
| req_erl | input | 1 | Error-level status flag |
| tlb_req_valid | output | 1 | Lookup issued to the TLB |
| tlb_vaddr | output | 32 | Address to look up |
| tlb_rsp_valid | input | 1 | TLB answer present |
| tlb_rsp_code | input | 3 | TLB result code |
| tlb_rsp_pa | input | PA_W | TLB physical address |
| tlb_rsp_rd | input | 1 | TLB read permission |
| tlb_rsp_wr | input | 1 | TLB write permission |
| out_valid | output | 1 | Result present (one-cycle pulse) |
| out_code | output | 3 | Result code, 000 match, 111 bad address |
| out_pa | output | PA_W | Physical address |
| out_rd | output | 1 | Read permitted |
| out_wr | output | 1 | Write permitted |

## Verification
Two events compete for the result register: a TLB answer and the acceptance of a new request. The first collision is a TLB answer in the same cycle as the lookup it belongs to. The bench drives tlb_rsp_valid in the request cycle and judges that req_ready never drops and the forwarded values appear one cycle later. The second collision holds a direct request on the inputs throughout a slow lookup, including the answer cycle. The bench checks that the output carries the TLB answer and not the waiting request, and that the waiting request completes one cycle after ready returns.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   localparam int RC_W = 3;
   localparam logic [RC_W-1:0] RC_MATCH   = 3'b000;
   localparam logic [RC_W-1:0] RC_BADADDR = 3'b111;

   typedef enum logic [1:0] {
      PRIV_KERNEL = 2'b00,
      PRIV_SUPER  = 2'b01,
      PRIV_USER   = 2'b10,
      PRIV_USER_X = 2'b11
   } priv_e;

   typedef enum logic [1:0] {
      ROUTE_DIRECT = 2'b00,
      ROUTE_TLB    = 2'b01,
      ROUTE_FAULT  = 2'b10
   } route_e;

endpackage

// File: rtl/vsd_classify.sv
module vsd_classify
   import vsd_pkg::*;
#(
   parameter int          VA_W       = 32,
   parameter int          PA_W       = 32,
   parameter bit          FIXED_MAP  = 1'b0,
   parameter logic [31:0] FIX_OFFSET = 32'h4000_0000
) (
   input  logic [VA_W-1:0] vaddr,
   input  logic [1:0]      priv,
   input  logic            erl,
   output route_e          route,
   output logic [PA_W-1:0] direct_pa
);

   localparam int LOW_BITS = VA_W - 3;

   generate
      if (FIXED_MAP) begin : g_fixed
         logic [VA_W-1:0] low_pa;
         assign low_pa = erl ? vaddr : vaddr + FIX_OFFSET;
         always_comb begin
            route = ROUTE_DIRECT;
            if (!vaddr[VA_W-1])
               direct_pa = PA_W'(low_pa);
            else if (!vaddr[VA_W-2])
               direct_pa = PA_W'({3'b000, vaddr[LOW_BITS-1:0]});
            else
               direct_pa = PA_W'(vaddr);
         end
      end else begin : g_segment
         priv_e lvl;
         logic  is_kern;
         logic  is_sup;
         assign lvl     = priv_e'(priv);
         assign is_kern = (lvl == PRIV_KERNEL);
         assign is_sup  = (lvl == PRIV_SUPER);
         always_comb begin
            route     = ROUTE_FAULT;
            direct_pa = '0;
            if (!vaddr[VA_W-1]) begin
               if (erl) begin
                  route     = ROUTE_DIRECT;
                  direct_pa = PA_W'(vaddr);
               end else begin
                  route = ROUTE_TLB;
               end
            end else begin
               case (vaddr[VA_W-2:VA_W-3])
                  2'b00, 2'b01: begin
                     if (is_kern) begin
                        route     = ROUTE_DIRECT;
                        direct_pa = PA_W'({3'b000, vaddr[LOW_BITS-1:0]});
                     end
                  end
                  2'b10: if (is_kern || is_sup) route = ROUTE_TLB;
                  default: if (is_kern) route = ROUTE_TLB;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vsd_resp_stage.sv
module vsd_resp_stage
   import vsd_pkg::*;
#(
   parameter int PA_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dir_take,
   input  route_e          dir_route,
   input  logic [PA_W-1:0] dir_pa,
   input  logic            tlb_fire,
   input  logic            tlb_rsp_valid,
   input  logic [RC_W-1:0] tlb_rsp_code,
   input  logic [PA_W-1:0] tlb_rsp_pa,
   input  logic            tlb_rsp_rd,
   input  logic            tlb_rsp_wr,
   output logic            pending,
   output logic            out_valid,
   output logic [RC_W-1:0] out_code,
   output logic [PA_W-1:0] out_pa,
   output logic            out_rd,
   output logic            out_wr
);

   logic rsp_take;
   assign rsp_take = tlb_rsp_valid && (pending || tlb_fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         out_valid <= 1'b0;
         out_code  <= RC_MATCH;
         out_pa    <= '0;
         out_rd    <= 1'b0;
         out_wr    <= 1'b0;
      end else begin
         pending <= (pending || tlb_fire) && !tlb_rsp_valid;
         if (rsp_take) begin
            out_valid <= 1'b1;
            out_code  <= tlb_rsp_code;
            out_pa    <= tlb_rsp_pa;
            out_rd    <= tlb_rsp_rd;
            out_wr    <= tlb_rsp_wr;
         end else if (dir_take) begin
            out_valid <= 1'b1;
            if (dir_route == ROUTE_DIRECT) begin
               out_code <= RC_MATCH;
               out_pa   <= dir_pa;
               out_rd   <= 1'b1;
               out_wr   <= 1'b1;
            end else begin
               out_code <= RC_BADADDR;
               out_pa   <= '0;
               out_rd   <= 1'b0;
               out_wr   <= 1'b0;
            end
         end else begin
            out_valid <= 1'b0;
         end
      end
   end

   // R8: a taken TLB answer is forwarded unchanged one cycle later
   assert_tlb_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_take |=> out_valid && out_code == $past(tlb_rsp_code)
                   && out_pa == $past(tlb_rsp_pa) && out_rd == $past(tlb_rsp_rd)
                   && out_wr == $past(tlb_rsp_wr));

   // R8: an unanswered lookup leaves the stage waiting
   assert_lookup_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_fire && !tlb_rsp_valid |=> pending);

   // R6: a fault never grants access
   assert_fault_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dir_take && dir_route == ROUTE_FAULT |=> out_code == RC_BADADDR && !out_rd && !out_wr);

endmodule

// File: rtl/vaddr_seg_decode.sv
module vaddr_seg_decode
   import vsd_pkg::*;
#(
   parameter int          VA_W       = 32,
   parameter int          PA_W       = 32,
   parameter bit          FIXED_MAP  = 1'b0,
   parameter logic [31:0] FIX_OFFSET = 32'h4000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [1:0]      req_priv,
   input  logic            req_erl,
   output logic            tlb_req_valid,
   output logic [VA_W-1:0] tlb_vaddr,
   input  logic            tlb_rsp_valid,
   input  logic [RC_W-1:0] tlb_rsp_code,
   input  logic [PA_W-1:0] tlb_rsp_pa,
   input  logic            tlb_rsp_rd,
   input  logic            tlb_rsp_wr,
   output logic            out_valid,
   output logic [RC_W-1:0] out_code,
   output logic [PA_W-1:0] out_pa,
   output logic            out_rd,
   output logic            out_wr
);

   generate
      if (VA_W != 32) begin : g_va_chk
         $error("vaddr_seg_decode: segment boundaries need VA_W == 32");
      end
      if (PA_W < 32) begin : g_pa_chk
         $error("vaddr_seg_decode: PA_W must be at least 32");
      end
   endgenerate

   route_e          route;
   logic [PA_W-1:0] direct_pa;
   logic            pending;
   logic            fire;

   vsd_classify #(
      .VA_W(VA_W), .PA_W(PA_W), .FIXED_MAP(FIXED_MAP), .FIX_OFFSET(FIX_OFFSET)
   ) u_classify (
      .vaddr(req_vaddr), .priv(req_priv), .erl(req_erl),
      .route(route), .direct_pa(direct_pa)
   );

   assign req_ready     = !pending;
   assign fire          = req_valid && req_ready;
   assign tlb_req_valid = fire && (route == ROUTE_TLB);
   assign tlb_vaddr     = req_vaddr;

   vsd_resp_stage #(.PA_W(PA_W)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .dir_take(fire && (route != ROUTE_TLB)), .dir_route(route), .dir_pa(direct_pa),
      .tlb_fire(tlb_req_valid),
      .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_code(tlb_rsp_code), .tlb_rsp_pa(tlb_rsp_pa),
      .tlb_rsp_rd(tlb_rsp_rd), .tlb_rsp_wr(tlb_rsp_wr),
      .pending(pending),
      .out_valid(out_valid), .out_code(out_code), .out_pa(out_pa),
      .out_rd(out_rd), .out_wr(out_wr)
   );

   // R7: a request completed locally is reported in the next cycle
   assert_direct_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !tlb_req_valid |=> out_valid);

   // R2/R3: the two unmapped upper windows land in the low 512 MB
   assert_kseg_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !tlb_req_valid && req_vaddr[31:30] == 2'b10 && route == ROUTE_DIRECT
      |=> out_pa[31:29] == 3'b000);

   generate
      if (FIXED_MAP) begin : g_fix_chk
         // R9: the low half gets the fixed offset when the error flag is clear
         assert_fix_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fire && !req_vaddr[31] && !req_erl
            |=> out_pa == PA_W'($past(req_vaddr) + FIX_OFFSET) && out_code == RC_MATCH);
      end else begin : g_seg_chk
         // R1: low addresses without the error flag always reach the TLB
         assert_user_tlb_R1: assert property (@(posedge clk) disable iff (!rst_n)
            fire && !req_vaddr[31] && !req_erl |-> tlb_req_valid);
         // R5: user level never reaches an upper-half address
         assert_user_high_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fire && req_priv[1] && req_vaddr[31] |=> out_valid && out_code == RC_BADADDR);
      end
   endgenerate

endmodule

// File: tb/vaddr_seg_decode_test.sv
module vaddr_seg_decode_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] K_DIR = 2'd0, K_MAP = 2'd1, K_BAD = 2'd2;
   // entry: priv(2) erl(1) kind(2) lat(2) vaddr(32) exp_pa(32)
   localparam int NV = 17;
   localparam logic [70:0] VEC [NV] = '{
      {2'b00, 1'b0, K_MAP, 2'd2, 32'h0000_1000, 32'h0},
      {2'b10, 1'b0, K_MAP, 2'd0, 32'h7FFF_F000, 32'h0},
      {2'b01, 1'b1, K_DIR, 2'd0, 32'h0040_0000, 32'h0040_0000},
      {2'b10, 1'b1, K_DIR, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
      {2'b00, 1'b0, K_DIR, 2'd0, 32'h8000_0000, 32'h0000_0000},
      {2'b00, 1'b0, K_DIR, 2'd0, 32'h9FFF_FFFF, 32'h1FFF_FFFF},
      {2'b00, 1'b1, K_DIR, 2'd0, 32'hA000_0010, 32'h0000_0010},
      {2'b00, 1'b0, K_DIR, 2'd0, 32'hBFC0_0000, 32'h1FC0_0000},
      {2'b01, 1'b0, K_BAD, 2'd0, 32'h8000_0000, 32'h0},
      {2'b10, 1'b0, K_BAD, 2'd0, 32'hA000_0000, 32'h0},
      {2'b01, 1'b0, K_MAP, 2'd1, 32'hC000_0000, 32'h0},
      {2'b10, 1'b0, K_BAD, 2'd0, 32'hDFFF_FFFF, 32'h0},
      {2'b00, 1'b0, K_MAP, 2'd3, 32'hE000_0000, 32'h0},
      {2'b01, 1'b0, K_BAD, 2'd0, 32'hFFFF_FFFF, 32'h0},
      {2'b11, 1'b0, K_BAD, 2'd0, 32'hC000_1000, 32'h0},
      {2'b11, 1'b1, K_DIR, 2'd0, 32'h0000_0004, 32'h0000_0004},
      {2'b00, 1'b1, K_MAP, 2'd0, 32'hC000_0000, 32'h0}
   };
   // fixed map entry: erl(1) vaddr(32) exp_pa(32)
   localparam int NF = 7;
   localparam logic [64:0] FVEC [NF] = '{
      {1'b0, 32'h1234_5678, 32'h5234_5678},
      {1'b1, 32'h1234_5678, 32'h1234_5678},
      {1'b0, 32'h7FFF_FFFF, 32'hBFFF_FFFF},
      {1'b0, 32'h9ABC_DEF0, 32'h1ABC_DEF0},
      {1'b1, 32'hBFFF_FFFF, 32'h1FFF_FFFF},
      {1'b0, 32'hC000_0000, 32'hC000_0000},
      {1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFC}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_priv = '0;
   logic        req_erl = 1'b0;
   logic        tlb_rsp_valid = 1'b0;
   logic [2:0]  tlb_rsp_code = '0;
   logic [31:0] tlb_rsp_pa = '0;
   logic        tlb_rsp_rd = 1'b0;
   logic        tlb_rsp_wr = 1'b0;
   logic        req_ready, tlb_req_valid, out_valid, out_rd, out_wr;
   logic [31:0] tlb_vaddr, out_pa;
   logic [2:0]  out_code;

   logic        f_valid = 1'b0;
   logic [31:0] f_vaddr = '0;
   logic [1:0]  f_priv = 2'b10;
   logic        f_erl = 1'b0;
   logic        f_ready, f_tlb_valid, f_out_valid, f_rd, f_wr;
   logic [31:0] f_tlb_vaddr, f_pa;
   logic [2:0]  f_code;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vaddr_seg_decode uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_priv(req_priv), .req_erl(req_erl),
      .tlb_req_valid(tlb_req_valid), .tlb_vaddr(tlb_vaddr),
      .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_code(tlb_rsp_code), .tlb_rsp_pa(tlb_rsp_pa),
      .tlb_rsp_rd(tlb_rsp_rd), .tlb_rsp_wr(tlb_rsp_wr),
      .out_valid(out_valid), .out_code(out_code), .out_pa(out_pa),
      .out_rd(out_rd), .out_wr(out_wr)
   );

   vaddr_seg_decode #(.FIXED_MAP(1'b1)) uut_fixed (
      .clk(clk), .rst_n(rst_n), .req_valid(f_valid), .req_ready(f_ready),
      .req_vaddr(f_vaddr), .req_priv(f_priv), .req_erl(f_erl),
      .tlb_req_valid(f_tlb_valid), .tlb_vaddr(f_tlb_vaddr),
      .tlb_rsp_valid(1'b0), .tlb_rsp_code(3'b000), .tlb_rsp_pa(32'h0),
      .tlb_rsp_rd(1'b0), .tlb_rsp_wr(1'b0),
      .out_valid(f_out_valid), .out_code(f_code), .out_pa(f_pa),
      .out_rd(f_rd), .out_wr(f_wr)
   );

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic string seg_tag(input logic [31:0] va, input logic [1:0] kind);
      if (kind == K_BAD) return "R6";
      if (!va[31]) return "R1";
      case (va[30:29])
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk_out(input string t, input logic [2:0] c, input logic [31:0] pa,
                          input logic rd, input logic wr);
      chk({t, " out_valid"}, 64'(out_valid), 64'(1'b1));
      chk({t, " out_code"}, 64'(out_code), 64'(c));
      chk({t, " out_pa"}, 64'(out_pa), 64'(pa));
      chk({t, " out_rd"}, 64'(out_rd), 64'(rd));
      chk({t, " out_wr"}, 64'(out_wr), 64'(wr));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R10: state during and just after reset
      @(negedge clk);
      chk("R10 out_valid in reset", 64'(out_valid), 64'(0));
      chk("R10 ready in reset", 64'(req_ready), 64'(1));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 out_valid after reset", 64'(out_valid), 64'(0));
      chk("R10 tlb_req_valid after reset", 64'(tlb_req_valid), 64'(0));
      chk("R10 ready after reset", 64'(req_ready), 64'(1));
      chk("R10 fixed ready after reset", 64'(f_ready), 64'(1));

      // table walk over the segment decoder
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  pv   = VEC[i][70:69];
         logic        er   = VEC[i][68];
         logic [1:0]  kind = VEC[i][67:66];
         int          lat  = int'(VEC[i][65:64]);
         logic [31:0] va   = VEC[i][63:32];
         logic [31:0] epa  = VEC[i][31:0];
         logic [2:0]  rcode = 3'(i);
         logic [31:0] rpa   = 32'hF000_0000 ^ va;
         string       t    = seg_tag(va, kind);
         @(negedge clk);
         req_valid = 1'b1; req_vaddr = va; req_priv = pv; req_erl = er;
         if (kind == K_MAP && lat == 0) begin
            tlb_rsp_valid = 1'b1; tlb_rsp_code = rcode; tlb_rsp_pa = rpa;
            tlb_rsp_rd = 1'b1; tlb_rsp_wr = i[0];
         end
         #1;
         chk({t, " ready at request"}, 64'(req_ready), 64'(1));
         chk({t, " tlb_req_valid"}, 64'(tlb_req_valid), 64'(kind == K_MAP));
         if (kind == K_MAP) chk({t, " tlb_vaddr"}, 64'(tlb_vaddr), 64'(va));
         @(negedge clk);
         req_valid = 1'b0; tlb_rsp_valid = 1'b0;
         if (kind == K_MAP && lat > 0) begin
            for (int c = 1; c <= lat; c++) begin
               if (c > 1) @(negedge clk);
               chk("R8 no output while waiting", 64'(out_valid), 64'(0));
               chk("R8 ready low while waiting", 64'(req_ready), 64'(0));
            end
            tlb_rsp_valid = 1'b1; tlb_rsp_code = rcode; tlb_rsp_pa = rpa;
            tlb_rsp_rd = 1'b1; tlb_rsp_wr = i[0];
            @(negedge clk);
            tlb_rsp_valid = 1'b0;
         end
         if (kind == K_MAP) begin
            chk_out({t, " R8 passthrough"}, rcode, rpa, 1'b1, i[0]);
            chk("R8 ready after answer", 64'(req_ready), 64'(1));
         end else if (kind == K_DIR) begin
            chk_out({t, " direct"}, 3'b000, epa, 1'b1, 1'b1);
         end else begin
            chk_out({t, " fault"}, 3'b111, 32'h0, 1'b0, 1'b0);
         end
      end

      // R7: the result is a one-cycle pulse
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h8000_0040; req_priv = 2'b00; req_erl = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk_out("R7 kernel direct", 3'b000, 32'h0000_0040, 1'b1, 1'b1);
      @(negedge clk);
      chk("R7 pulse ends", 64'(out_valid), 64'(0));

      // R8: a direct request held through a slow lookup is not taken early
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h0000_2000; req_priv = 2'b10; req_erl = 1'b0;
      @(negedge clk);
      req_vaddr = 32'hA000_0100; req_priv = 2'b00;
      #1;
      chk("R8 held request not issued", 64'(tlb_req_valid), 64'(0));
      @(negedge clk);
      chk("R8 held request gives no output", 64'(out_valid), 64'(0));
      tlb_rsp_valid = 1'b1; tlb_rsp_code = 3'b110; tlb_rsp_pa = 32'h0ABC_0000;
      tlb_rsp_rd = 1'b0; tlb_rsp_wr = 1'b0;
      @(negedge clk);
      tlb_rsp_valid = 1'b0;
      chk_out("R8 answer wins over held request", 3'b110, 32'h0ABC_0000, 1'b0, 1'b0);
      chk("R8 ready back", 64'(req_ready), 64'(1));
      @(negedge clk);
      req_valid = 1'b0;
      chk_out("R3 held request completes", 3'b000, 32'h0000_0100, 1'b1, 1'b1);

      // R9: fixed mapping variant
      for (int j = 0; j < NF; j++) begin
         @(negedge clk);
         f_valid = 1'b1; f_erl = FVEC[j][64]; f_vaddr = FVEC[j][63:32];
         f_priv = 2'(j);
         #1;
         chk("R9 no lookup", 64'(f_tlb_valid), 64'(0));
         @(negedge clk);
         f_valid = 1'b0;
         chk("R9 valid", 64'(f_out_valid), 64'(1));
         chk("R9 code", 64'(f_code), 64'(3'b000));
         chk("R9 pa", 64'(f_pa), 64'(FVEC[j][31:0]));
         chk("R9 perms", 64'({f_rd, f_wr}), 64'(2'b11));
      end

      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule